// File: doc/BRIEF.md
# Decoding Integer ALU Slice

This block is a purely combinational slice of an integer execute stage. It takes one 32-bit instruction word and the two values already read from the register file for it, the first source (`rs`) and the second source (`rt`). From these it produces the 32-bit value to write back, the index of the register to write, and a write enable. The block decodes the opcode and function fields itself, so the surrounding pipeline only has to supply operands and route the three outputs to the register file write port.

The slice covers register-register add, subtract, OR, XOR and NOR. It also covers shifts by a constant amount, and the immediate add, AND, OR and load-upper forms. Each immediate instruction applies its own extension of the 16-bit constant: sign extension for the add, zero extension for the logic operations. Any instruction outside this set leaves the write enable low. So does any instruction that would target register 0.

Top module: `int_alu_decode`

## Requirements
- R1: With opcode (bits 31:26) equal to 0, function (bits 5:0) 0x21 yields rs+rt and function 0x23 yields rs-rt, both modulo 2^32 with no trap or flag.
- R2: With opcode 0, function 0x25 yields rs|rt, 0x26 yields rs^rt, and 0x27 yields ~(rs|rt).
- R3: With opcode 0, function 0x00 shifts rt left by shamt (bits 10:6). Function 0x02 shifts rt right, filling with zeros. Function 0x03 shifts rt right, filling with rt bit 31.
- R4: Opcode 0x09 yields rs plus the immediate (bits 15:0) sign-extended to 32 bits.
- R5: Opcode 0x0C yields rs AND the zero-extended immediate; opcode 0x0D yields rs OR the zero-extended immediate.
- R6: Opcode 0x0F yields the immediate in bits 31:16 with bits 15:0 zero, regardless of rs.
- R7: The destination index is bits 15:11 for opcode 0 and bits 20:16 for the immediate opcodes.
- R8: Any opcode other than 0x00, 0x09, 0x0C, 0x0D, 0x0F, and any function under opcode 0 other than 0x00, 0x02, 0x03, 0x21, 0x23, 0x25, 0x26, 0x27, gives a write enable of 0.
- R9: A recognised instruction whose destination index is 0 gives a write enable of 0; otherwise a recognised instruction gives a write enable of 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Instruction word to decode |
| rs_val | input | 32 | Value of the first source register |
| rt_val | input | 32 | Value of the second source register |
| result | output | 32 | Value to write back |
| dest | output | 5 | Index of the register to write |
| wr_en | output | 1 | Write enable for the register file |

## Verification
The checker relies on settled, fully known inputs. It evaluates its properties only when the instruction and both operands carry no X or Z bits, and it relies on the outputs being a pure function of those inputs. The bench keeps within these limits: it drives every input to a known value before the first check and changes inputs only at falling clock edges. It then samples a nanosecond later, so the operands are never partial when results are compared.

// File: rtl/int_alu_decode.sv
module int_alu_decode (
  input  logic [31:0] instr,
  input  logic [31:0] rs_val,
  input  logic [31:0] rt_val,
  output logic [31:0] result,
  output logic [4:0]  dest,
  output logic        wr_en
);

  localparam logic [5:0] OP_REG   = 6'h00;
  localparam logic [5:0] OP_ADDI  = 6'h09;
  localparam logic [5:0] OP_ANDI  = 6'h0C;
  localparam logic [5:0] OP_ORI   = 6'h0D;
  localparam logic [5:0] OP_UPPER = 6'h0F;

  localparam logic [5:0] FN_SHL   = 6'h00;
  localparam logic [5:0] FN_SHRL  = 6'h02;
  localparam logic [5:0] FN_SHRA  = 6'h03;
  localparam logic [5:0] FN_ADD   = 6'h21;
  localparam logic [5:0] FN_SUB   = 6'h23;
  localparam logic [5:0] FN_OR    = 6'h25;
  localparam logic [5:0] FN_XOR   = 6'h26;
  localparam logic [5:0] FN_NOR   = 6'h27;

  wire [5:0]  opc   = instr[31:26];
  wire [5:0]  fn    = instr[5:0];
  wire [4:0]  shamt = instr[10:6];
  wire [15:0] imm   = instr[15:0];

  wire [31:0] imm_sx = {{16{imm[15]}}, imm};
  wire [31:0] imm_zx = {16'h0000, imm};

  logic        known;
  logic [31:0] value;

  always_comb begin
    known = 1'b1;
    value = 32'h0;
    unique case (opc)
      OP_REG: begin
        unique case (fn)
          FN_SHL:  value = rt_val << shamt;
          FN_SHRL: value = rt_val >> shamt;
          FN_SHRA: value = $unsigned($signed(rt_val) >>> shamt);
          FN_ADD:  value = rs_val + rt_val;
          FN_SUB:  value = rs_val - rt_val;
          FN_OR:   value = rs_val | rt_val;
          FN_XOR:  value = rs_val ^ rt_val;
          FN_NOR:  value = ~(rs_val | rt_val);
          default: known = 1'b0;
        endcase
      end
      OP_ADDI:  value = rs_val + imm_sx;
      OP_ANDI:  value = rs_val & imm_zx;
      OP_ORI:   value = rs_val | imm_zx;
      OP_UPPER: value = {imm, 16'h0000};
      default:  known = 1'b0;
    endcase
  end

  assign dest   = (opc == OP_REG) ? instr[15:11] : instr[20:16];
  assign result = value;
  assign wr_en  = known && (dest != 5'd0);

endmodule

// File: rtl/int_alu_decode_chk.sv
module int_alu_decode_chk (
  input logic [31:0] instr,
  input logic [31:0] rs_val,
  input logic [31:0] rt_val,
  input logic [31:0] result,
  input logic [4:0]  dest,
  input logic        wr_en
);

  always_comb begin
    if (!$isunknown({instr, rs_val, rt_val})) begin
      AST_SUB_INVERTS: assert (!(instr[31:26] == 6'h00 && instr[5:0] == 6'h23) || (result + rt_val == rs_val)); // R1
      AST_UPPER_LOW_ZERO: assert (!(instr[31:26] == 6'h0F) || (result[15:0] == 16'h0000)); // R6
      AST_ANDI_HIGH_ZERO: assert (!(instr[31:26] == 6'h0C) || (result[31:16] == 16'h0000)); // R5
      AST_REG_DEST: assert (!(wr_en && instr[31:26] == 6'h00) || (dest == instr[15:11])); // R7
      AST_IMM_DEST: assert (!(wr_en && instr[31:26] != 6'h00) || (dest == instr[20:16])); // R7
      AST_NO_ZERO_WRITE: assert (!wr_en || (dest != 5'd0)); // R9
      AST_LOAD_NO_WRITE: assert (!(instr[31:26] == 6'h23) || !wr_en); // R8
    end
  end

endmodule

bind int_alu_decode int_alu_decode_chk u_chk (.*);

// File: tb/int_alu_decode_tb.sv
module int_alu_decode_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [31:0] instr, rs_val, rt_val, result;
  logic [4:0]  dest;
  logic        wr_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int_alu_decode u_dut (
    .instr(instr), .rs_val(rs_val), .rt_val(rt_val),
    .result(result), .dest(dest), .wr_en(wr_en)
  );

  function automatic logic [31:0] rw(input logic [4:0] rs, input logic [4:0] rt,
                                     input logic [4:0] rd, input logic [4:0] sh,
                                     input logic [5:0] fn);
    return {6'h00, rs, rt, rd, sh, fn};
  endfunction

  function automatic logic [31:0] iw(input logic [5:0] op, input logic [4:0] rs,
                                     input logic [4:0] rt, input logic [15:0] k);
    return {op, rs, rt, k};
  endfunction

  // tag, instr, rs, rt, expected result, expected dest, expected enable
  typedef struct packed {
    logic [7:0]  tag;
    logic [31:0] ins;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] res;
    logic [4:0]  rd;
    logic        we;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{8'd1, rw(5'd1, 5'd2, 5'd3, 5'd0, 6'h21), 32'd5, 32'd7, 32'd12, 5'd3, 1'b1},                      // R1 add
    '{8'd1, rw(5'd1, 5'd2, 5'd6, 5'd0, 6'h21), 32'hFFFFFFFF, 32'd2, 32'd1, 5'd6, 1'b1},                // R1 wrap
    '{8'd1, rw(5'd1, 5'd2, 5'd4, 5'd0, 6'h23), 32'd5, 32'd7, 32'hFFFFFFFE, 5'd4, 1'b1},                // R1 sub
    '{8'd2, rw(5'd1, 5'd2, 5'd5, 5'd0, 6'h25), 32'hF0F00000, 32'h00000F0F, 32'hF0F00F0F, 5'd5, 1'b1},  // R2 or
    '{8'd2, rw(5'd1, 5'd2, 5'd7, 5'd0, 6'h26), 32'hFFFF0000, 32'h0F0F0F0F, 32'hF0F00F0F, 5'd7, 1'b1},  // R2 xor
    '{8'd2, rw(5'd1, 5'd2, 5'd8, 5'd0, 6'h27), 32'h0, 32'h0, 32'hFFFFFFFF, 5'd8, 1'b1},                // R2 nor
    '{8'd3, rw(5'd0, 5'd2, 5'd9, 5'd4, 6'h00), 32'hDEAD, 32'h3, 32'h30, 5'd9, 1'b1},                   // R3 left
    '{8'd3, rw(5'd0, 5'd2, 5'd10, 5'd31, 6'h02), 32'h0, 32'h80000000, 32'h1, 5'd10, 1'b1},             // R3 logical
    '{8'd3, rw(5'd0, 5'd2, 5'd11, 5'd4, 6'h03), 32'h0, 32'h80000000, 32'hF8000000, 5'd11, 1'b1},       // R3 arith neg
    '{8'd3, rw(5'd0, 5'd2, 5'd12, 5'd4, 6'h03), 32'h0, 32'h7FFFFFFF, 32'h07FFFFFF, 5'd12, 1'b1},       // R3 arith pos
    '{8'd4, iw(6'h09, 5'd1, 5'd9, 16'hFFFF), 32'd10, 32'h55, 32'd9, 5'd9, 1'b1},                       // R4 R7 imm dest
    '{8'd4, iw(6'h09, 5'd1, 5'd13, 16'h8000), 32'd0, 32'h0, 32'hFFFF8000, 5'd13, 1'b1},                // R4
    '{8'd5, iw(6'h0C, 5'd1, 5'd14, 16'h8001), 32'hFFFFFFFF, 32'h0, 32'h00008001, 5'd14, 1'b1},         // R5 and
    '{8'd5, iw(6'h0D, 5'd1, 5'd15, 16'h8000), 32'h12340000, 32'h0, 32'h12348000, 5'd15, 1'b1},         // R5 or
    '{8'd6, iw(6'h0F, 5'd1, 5'd16, 16'hBEEF), 32'hFFFFFFFF, 32'h0, 32'hBEEF0000, 5'd16, 1'b1},         // R6
    '{8'd9, rw(5'd1, 5'd2, 5'd0, 5'd0, 6'h21), 32'd1, 32'd1, 32'd0, 5'd0, 1'b0},                       // R9 reg dest 0
    '{8'd9, iw(6'h09, 5'd1, 5'd0, 16'h0001), 32'd1, 32'd0, 32'd0, 5'd0, 1'b0},                         // R9 imm dest 0
    '{8'd8, iw(6'h23, 5'd1, 5'd2, 16'h0004), 32'd1, 32'd0, 32'd0, 5'd0, 1'b0},                         // R8 opcode
    '{8'd8, rw(5'd1, 5'd2, 5'd3, 5'd0, 6'h20), 32'd1, 32'd1, 32'd0, 5'd0, 1'b0}                        // R8 function
  };

  task automatic apply(input logic [7:0] tag, input logic [31:0] ins, input logic [31:0] a,
                       input logic [31:0] b, input logic [31:0] res, input logic [4:0] rd,
                       input logic we);
    @(negedge clk);
    instr = ins; rs_val = a; rt_val = b;
    #1;
    checks++;
    if (wr_en !== we || (we && (result !== res || dest !== rd))) begin
      fails++;
      $display("FAIL R%0d instr=%h: got res=%h dest=%0d we=%b, exp res=%h dest=%0d we=%b",
               tag, ins, result, dest, wr_en, res, rd, we);
    end
  endtask

  initial begin
    instr = 32'h0; rs_val = 32'h0; rt_val = 32'h0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // idle word (shift into register 0) must not write: R9
    apply(8'd9, 32'h0, 32'h0, 32'h0, 32'h0, 5'd0, 1'b0);
    for (int i = 0; i < NV; i++)
      apply(VECS[i].tag, VECS[i].ins, VECS[i].a, VECS[i].b, VECS[i].res, VECS[i].rd, VECS[i].we);
    // R3 shift by zero keeps sign value
    apply(8'd3, rw(5'd0, 5'd2, 5'd17, 5'd0, 6'h03), 32'h0, 32'h80000001, 32'h80000001, 5'd17, 1'b1);
    // R7 register form ignores bits 20:16 for dest, rd = 31
    apply(8'd7, rw(5'd1, 5'd30, 5'd31, 5'd0, 6'h25), 32'h1, 32'h2, 32'h3, 5'd31, 1'b1);
    // R6 upper ignores rs
    apply(8'd6, iw(6'h0F, 5'd3, 5'd1, 16'h0001), 32'h12345678, 32'h0, 32'h00010000, 5'd1, 1'b1);
    // R8 unused opcode 0x3F
    apply(8'd8, iw(6'h3F, 5'd1, 5'd2, 16'hFFFF), 32'h1, 32'h1, 32'h0, 5'd0, 1'b0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule